// File: doc/BRIEF.md
# Phase-Shifted Multichannel PWM Generator

This block produces eight pulse-width-modulated outputs from one shared period counter. It does not compare a shared ramp against each duty value. Instead, each channel runs its own down-counter. That counter is reloaded at every period boundary, so that the counter and the shared up-counter keep a constant sum modulo 256, and that sum is the channel's duty. Every output rises on the tick where the shared counter wraps from 255 to 0. Each output falls on the tick where its own counter steps down to zero.

All output changes in a tick come from one change mask and are applied by one register update. Channels with equal duty therefore switch in the same clock cycle, with no skew between them, however many of them fall together.

Duty values are written one channel per clock over a small write port into shadow registers. A shadow value only reaches its working counter at the next period wrap, so a waveform is never altered in mid-period. Time advances only on cycles where the tick enable is high.

Top module: `pwm_phase_bank`

## Requirements
- R1: While reset is low, and after it is released, every output is 0. No output goes high before the first period wrap, which happens on the 256th tick after reset.
- R2: On a clock cycle where tick_en is 0, no output changes and the period position does not advance.
- R3: The period is 256 ticks. Every output whose newly loaded duty is nonzero goes high on the same tick: the tick on which the shared counter wraps from 255 to 0.
- R4: For a loaded duty d in 1..255, the output stays high for exactly d ticks after the wrap and goes low on the d-th tick. It never falls on a wrap tick.
- R5: A loaded duty of 0 keeps the output low for the whole period.
- R6: A loaded duty of 255 keeps the output high for 255 of the 256 ticks of the period.
- R7: A write (wr_en=1, channel wr_ch, value wr_duty) changes only a shadow register. No output changes until the next wrap, where the shadow value becomes the loaded duty.
- R8: A write made in the same clock cycle as the wrap tick does not affect the period starting at that wrap. It takes effect from the following wrap.
- R9: When all channels hold the same duty, including 255, every channel gives the correct width and all outputs switch in the same cycle.
- R10: Each write updates only the shadow register selected by wr_ch (0..7). The other channels keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Advances the period counter and the channel counters by one tick |
| wr_en | input | 1 | Write strobe for a shadow duty register |
| wr_ch | input | 3 | Channel index of the write |
| wr_duty | input | 8 | Duty value written, 0..255 ticks high per period |
| pwm_out | output | 8 | PWM outputs, bit n for channel n |

## Verification
A corrupted shared counter moves every rising edge at once. The next wrap then arrives at the wrong tick, which is visible within one period of 256 ticks. A channel counter that loses its offset shows up as a wrong pulse width on that one channel, at the falling edge of the same period. A shadow register that is loaded at the wrong time, or into the wrong channel, gives a wrong width at the first wrap after the write. The bench measures whole periods, so each of these faults is caught within two periods.

// File: rtl/pwm_ps_pkg.sv
// Package: shared widths and types for the phase-shifted PWM bank.
// Assumes: the period is 2**PS_CW ticks, and each channel counter has the same width.
package pwm_ps_pkg;
    parameter int unsigned PS_NCH = 8;
    parameter int unsigned PS_CW  = 8;
    typedef logic [PS_CW-1:0] ps_cnt_t;
endpackage

// File: rtl/pwm_period_ctr.sv
// Module: shared up-counter that sets the PWM period.
// Assumes: it advances only when tick_en is high. wrap is a same-cycle flag
// that marks the tick on which the count goes from all ones to zero.
module pwm_period_ctr #(
    parameter int unsigned CW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic wrap
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    logic [CW-1:0] cnt_q;

    // Decide whether this tick closes the period.
    always_comb wrap = tick_en && (cnt_q == TOP);

    // Count the ticks, modulo 2**CW.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (tick_en) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pwm_shadow_bank.sv
// Module: shadow duty registers, written one entry per clock.
// Assumes: wr_ch is below NCH. A value stays here until the period wrap copies it.
module pwm_shadow_bank #(
    parameter int unsigned NCH = 8,
    parameter int unsigned CW  = 8,
    localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IW-1:0]           wr_ch,
    input  logic [CW-1:0]           wr_duty,
    output logic [NCH-1:0][CW-1:0]  shadow
);
    for (genvar g = 0; g < NCH; g++) begin : g_ent
        // Store a new duty for the selected entry only.
        always_ff @(posedge clk) begin
            if (!rst_n)                          shadow[g] <= '0;
            else if (wr_en && (wr_ch == IW'(g))) shadow[g] <= wr_duty;
        end
    end
endmodule

// File: rtl/pwm_chan_ctr.sv
// Module: one channel's down-counter, kept at a fixed phase offset from the period.
// Assumes: wrap has priority over the plain decrement. At a wrap the counter
// loads the duty, so the counter and the period position keep a constant sum
// modulo 2**CW.
module pwm_chan_ctr #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          wrap,
    input  logic [CW-1:0] load_val,
    output logic          rise_req,
    output logic          fall_req
);
    logic [CW-1:0] cnt_q;

    // Raise the output at a wrap, unless the duty loaded there is zero.
    always_comb rise_req = wrap && (load_val != '0);

    // Lower the output on the tick that steps the counter down to zero.
    always_comb fall_req = tick_en && !wrap && (cnt_q == CW'(1));

    // Load at the wrap, otherwise count down once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (wrap)    cnt_q <= load_val;
        else if (tick_en) cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/pwm_phase_bank.sv
// Module: top of the eight-channel phase-shifted PWM generator.
// Assumes: one write per clock through the shadow port. All outputs are updated
// from one change mask per tick, so channels that switch together do so in
// the same cycle.
module pwm_phase_bank #(
    parameter int unsigned NCH = pwm_ps_pkg::PS_NCH,
    parameter int unsigned CW  = pwm_ps_pkg::PS_CW,
    localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_en,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_ch,
    input  logic [CW-1:0]  wr_duty,
    output logic [NCH-1:0] pwm_out
);
    logic                   wrap;
    logic [NCH-1:0][CW-1:0] shadow;
    logic [NCH-1:0]         rise_m;
    logic [NCH-1:0]         fall_m;
    logic [NCH-1:0]         chg_m;

    pwm_period_ctr #(.CW(CW)) u_per (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wrap(wrap)
    );

    pwm_shadow_bank #(.NCH(NCH), .CW(CW)) u_shd (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_duty(wr_duty), .shadow(shadow)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_chan_ctr #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wrap(wrap),
            .load_val(shadow[g]), .rise_req(rise_m[g]), .fall_req(fall_m[g])
        );
    end

    // Build the single mask of the output bits that change on this tick.
    always_comb chg_m = wrap ? (pwm_out ^ rise_m) : (pwm_out & fall_m);

    // Apply the mask to every output in one update.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_out <= '0;
        else        pwm_out <= pwm_out ^ chg_m;
    end
endmodule

// File: rtl/pwm_phase_bank_chk.sv
// Module: protocol checker for pwm_phase_bank, attached with bind.
// Assumes: it keeps its own tick counter, modulo 2**W, started at reset, as an
// independent view of the period position.
module pwm_phase_bank_chk #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_en,
    input logic [N-1:0] pwm_out
);
    logic [W-1:0] pos_q;

    // Track the ticks seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       pos_q <= '0;
        else if (tick_en) pos_q <= pos_q + 1'b1;
    end

    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_en) |-> (pwm_out == $past(pwm_out)));

    assert_rise_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pwm_out & ~$past(pwm_out))) |-> (pos_q == '0 && $past(tick_en)));

    assert_no_fall_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pwm_out) & ~pwm_out)) |-> (pos_q != '0 && $past(tick_en)));
endmodule

bind pwm_phase_bank pwm_phase_bank_chk #(.N(NCH), .W(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwm_out(pwm_out)
);

// File: tb/sim_pwm_phase_bank.sv
module sim_pwm_phase_bank;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_ch = '0;
    logic [7:0] wr_duty = '0;
    logic [7:0] pwm_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int unsigned m_shadow [8];
    int unsigned m_loaded [8];
    int unsigned m_t = 0;
    bit m_started = 0;

    pwm_phase_bank u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_ch(wr_ch), .wr_duty(wr_duty), .pwm_out(pwm_out)
    );

    always #(CLK_P/2) clk = ~clk;

    // Expected outputs from the model: high while the period position is below the loaded duty.
    function automatic logic [7:0] exp_out();
        logic [7:0] e = '0;
        for (int c = 0; c < 8; c++)
            e[c] = m_started && (m_t < m_loaded[c]);
        return e;
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive the inputs, update the model at the edge, compare outputs after the edge.
    task automatic step(input bit tk, input bit we, input int ch, input int val, input string tag);
        tick_en = tk; wr_en = we; wr_ch = ch[2:0]; wr_duty = val[7:0];
        @(posedge clk);
        if (tk) begin
            m_t = (m_t + 1) % 256;
            if (m_t == 0) begin
                m_started = 1;
                for (int c = 0; c < 8; c++) m_loaded[c] = m_shadow[c];
            end
        end
        if (we) m_shadow[ch] = val;
        #(CLK_P/4);
        tick_en = 0; wr_en = 0;
        check(int'(pwm_out), int'(exp_out()), tag);
    endtask

    // Tick until the next tick is the wrap tick.
    task automatic align(input string tag);
        while (m_t != 255) step(1, 0, 0, 0, tag);
    endtask

    // From just before a wrap, run one whole period and check each channel's high count.
    task automatic measure(input string tag);
        int hi [8];
        for (int c = 0; c < 8; c++) hi[c] = 0;
        for (int k = 0; k < 256; k++) begin
            step(1, 0, 0, 0, tag);
            for (int c = 0; c < 8; c++) if (pwm_out[c]) hi[c]++;
        end
        for (int c = 0; c < 8; c++) check(hi[c], int'(m_loaded[c]), tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int c = 0; c < 8; c++) begin m_shadow[c] = 0; m_loaded[c] = 0; end
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check(int'(pwm_out), 0, "R1 reset");
        rst_n = 1'b1;

        // R1 and R7: writes in the first period change no output before the first wrap.
        for (int c = 0; c < 8; c++) step(1, 1, c, 16 * c + 9, "R7 first period");
        for (int k = 0; k < 200; k++) step(1, 0, 0, 0, "R1 no early rise");
        align("R7");
        measure("R4 R7 staggered widths");

        // R2: idle gaps, with tick_en low on random cycles.
        for (int k = 0; k < 700; k++) step(1'($urandom % 2), 0, 0, 0, "R2 tick gaps");

        // R6 and R9: every channel at 255.
        for (int c = 0; c < 8; c++) step(1, 1, c, 255, "R9 write all 255");
        align("R9");
        step(1, 0, 0, 0, "R3 wrap");
        align("R6");
        measure("R6 R9 all 255");

        // R9: every channel at 128, so all outputs fall together.
        for (int c = 0; c < 8; c++) step(1, 1, c, 128, "R9 write all 128");
        align("R9");
        step(1, 0, 0, 0, "R9");
        align("R9");
        measure("R9 all 128");

        // R5: zero duty on every channel.
        for (int c = 0; c < 8; c++) step(1, 1, c, 0, "R5 write zero");
        align("R5");
        step(1, 0, 0, 0, "R5");
        align("R5");
        measure("R5 zero duty");

        // R8: a write on the wrap tick itself waits one more period.
        align("R8");
        step(1, 1, 3, 77, "R8 write on wrap");
        check(int'(pwm_out[3]), 0, "R8 old duty kept");
        align("R8");
        measure("R8 next period");

        // R10 and R3: random single writes, each followed by a whole period.
        for (int r = 0; r < 6; r++) begin
            int ch = int'($urandom % 8);
            int v  = int'($urandom % 256);
            step(1, 1, ch, v, "R10 single write");
            for (int k = 0; k < 40; k++) step(1'($urandom % 4 != 0), 0, 0, 0, "R3 random");
            align("R10");
            measure("R10 R4 random widths");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule